// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a synchronous binary up-counter built from 4-bit slices. Each slice holds a nibble that changes only on the rising clock edge. The action on each edge is picked in a fixed order of precedence:

1. an active-low clear,
2. an active-low parallel load,
3. a count,
4. a hold.

Two active-high enables must both be high for a slice to count. One is the parallel enable and the other is the trickle enable. Each slice has a terminal-count flag. The flag is high when the slice's nibble is all ones and its trickle enable is high. The parallel enable has no effect on the flag.

The top level chains `N` slices into a `4*N`-bit counter using lookahead enable wiring:

- The first slice takes both external enables.
- Every later slice takes its parallel enable from the first slice's terminal count, ANDed with the external parallel enable.
- Every later slice takes its trickle enable from the terminal count of the slice before it.

With this wiring the carry ripples through the trickle path only. The whole chain steps, and wraps, as one binary counter on a single edge. The last slice's terminal count is brought out. It lets the wide counter in turn be chained to further stages.

The terminal count is combinational, decoded from registered state and the trickle enable. It is meant as an enable for the next stage. It is not meant to act as a clock or as an asynchronous reset.

Top module: `cascade_counter`

## Requirements
- R1: In each slice, a count edge takes the nibble from value v to (v+1) mod 16, so 15 is followed by 0.
- R2: When `clr_n` is 0 at a rising edge, the whole count becomes 0, whatever `load_n`, the enables and `din` are.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din` (bit i of `din` goes to bit i of `count`), whatever the enables are.
- R4: With `clr_n` and `load_n` both 1, the counter increments only if `en_par` and `en_trk` are both 1. If either is 0, `count` keeps its value.
- R5: `tc_out` is 1 exactly when `count` is all ones and `en_trk` is 1. Its value does not depend on `en_par`, and it responds combinationally to `en_trk` within the same cycle.
- R6: With `N` slices, `count` is a `4*N`-bit value. A count edge adds 1 to it modulo 2^(4*N), and every carry between slices completes within that same edge.
- R7: A count edge taken when `count` is all ones makes the whole `count` 0 in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high; also gates the terminal count |
| din | input | 4*N | Parallel data word used by a load |
| count | output | 4*N | Registered counter value |
| tc_out | output | 1 | Terminal count of the last slice |

## Verification
The assertions assume that the counter has been cleared at least once before any check depends on its earlier value. They also assume that the controls are steady around each rising edge. The stimulus meets both assumptions. It holds `clr_n` low for the first edges. It changes every control and `din` only on the falling clock edge.

The sequences cover these cases:

- a load issued in the middle of a counting run;
- a clear issued together with a load;
- the enables held low while the count is all ones;
- a complete wrap of the whole chain.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int SLICE_W = 4;
    typedef logic [SLICE_W-1:0] nib_t;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_t;

    typedef struct packed {
        nib_t val;
    } slice_state_t;
endpackage

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] val,
    input  logic         en_trk,
    output logic         tc
);
    always_comb begin
        tc = en_trk & (&val);
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic load_n,
    input  logic en_par,
    input  logic en_trk,
    input  nib_t din,
    output nib_t q,
    output logic tc
);
    localparam nib_t MAX_VAL = {SLICE_W{1'b1}};

    slice_state_t st_d, st_q;
    mode_t        mode_d;

    always_comb begin
        if (!clr_n)
            mode_d = MODE_CLEAR;
        else if (!load_n)
            mode_d = MODE_LOAD;
        else if (en_par && en_trk)
            mode_d = MODE_COUNT;
        else
            mode_d = MODE_HOLD;

        st_d = st_q;
        case (mode_d)
            MODE_CLEAR: st_d.val = '0;
            MODE_LOAD:  st_d.val = din;
            MODE_COUNT: st_d.val = st_q.val + 1'b1;
            default:    st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;

    cnt_tc_decode #(.W(SLICE_W)) u_tc (
        .val    (st_q.val),
        .en_trk (en_trk),
        .tc     (tc)
    );

    assert_clear_wins_R2: assert property (@(posedge clk)
        !clr_n |=> q == '0);

    assert_load_copies_R3: assert property (@(posedge clk)
        clr_n && !load_n |=> q == $past(din));

    assert_hold_when_disabled_R4: assert property (@(posedge clk)
        clr_n && load_n && !(en_par && en_trk) |=> $stable(q));

    assert_step_one_R1: assert property (@(posedge clk)
        clr_n && load_n && en_par && en_trk && q != MAX_VAL |=> q == nib_t'($past(q) + 1'b1));

    assert_wrap_slice_R1: assert property (@(posedge clk)
        clr_n && load_n && en_par && en_trk && q == MAX_VAL |=> q == '0);

    assert_tc_gate_R5: assert property (@(posedge clk)
        tc |-> (en_trk && q == MAX_VAL));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int N = 2
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic                 load_n,
    input  logic                 en_par,
    input  logic                 en_trk,
    input  logic [SLICE_W*N-1:0] din,
    output logic [SLICE_W*N-1:0] count,
    output logic                 tc_out
);
    localparam int TOTAL_W = SLICE_W * N;

    logic [N-1:0] tc_vec;
    logic [N-1:0] par_vec;
    logic [N-1:0] trk_vec;

    for (genvar k = 0; k < N; k++) begin : g_slice
        if (k == 0) begin : g_first
            assign par_vec[k] = en_par;
            assign trk_vec[k] = en_trk;
        end else begin : g_rest
            assign par_vec[k] = tc_vec[0] & en_par;
            assign trk_vec[k] = tc_vec[k-1];
        end

        cnt_slice u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_par (par_vec[k]),
            .en_trk (trk_vec[k]),
            .din    (din[k*SLICE_W +: SLICE_W]),
            .q      (count[k*SLICE_W +: SLICE_W]),
            .tc     (tc_vec[k])
        );
    end

    assign tc_out = tc_vec[N-1];

    assert_chain_wrap_R7: assert property (@(posedge clk)
        clr_n && load_n && en_par && en_trk && (&count) |=> count == '0);

    assert_chain_step_R6: assert property (@(posedge clk)
        clr_n && load_n && en_par && en_trk && !(&count)
        |=> count == TOTAL_W'($past(count) + 1'b1));

    assert_chain_tc_R5: assert property (@(posedge clk)
        tc_out |-> (en_trk && (&count)));
endmodule

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
    localparam int N = 2;
    localparam int W = 4 * N;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc_out;

    int errors = 0;
    int checks = 0;
    int model = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_counter #(.N(N)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .count(count), .tc_out(tc_out)
    );

    task automatic compare(input string tag);
        int  exp_c = model;
        bit  exp_t = (model == (1 << W) - 1) && en_trk;
        checks++;
        if (count !== W'(exp_c) || tc_out !== exp_t) begin
            errors++;
            $display("FAIL %s: count=%0h tc=%0b expected count=%0h tc=%0b",
                     tag, count, tc_out, exp_c, exp_t);
        end
    endtask

    // Drive at the falling edge, apply the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit c, input bit l, input bit p, input bit t,
                        input logic [W-1:0] d, input string tag);
        clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
        @(posedge clk);
        if (!c)
            model = 0;
        else if (!l)
            model = int'(d);
        else if (p && t)
            model = (model + 1) % (1 << W);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 1, 1, 8'hA5, "R2 clear at start");
        step(0, 1, 1, 1, 8'h00, "R2 clear held");
        for (int i = 0; i < 20; i++)
            step(1, 1, 1, 1, 8'h00, "R1 R6 count from zero");
        step(1, 1, 0, 1, 8'h00, "R4 hold en_par low");
        step(1, 1, 1, 0, 8'h00, "R4 hold en_trk low");
        step(1, 0, 1, 1, 8'h3C, "R3 load during counting");
        step(1, 0, 0, 0, 8'h0F, "R3 load with enables low");
        step(1, 1, 1, 1, 8'h00, "R1 R6 carry into upper slice");
        step(0, 0, 1, 1, 8'h77, "R2 clear during load");
        step(1, 0, 0, 1, 8'hFF, "R3 load all ones");
        step(1, 1, 0, 1, 8'h00, "R5 tc high with en_par low");
        step(1, 1, 0, 0, 8'h00, "R5 tc low with en_trk low");
        step(1, 1, 1, 0, 8'h00, "R4 hold at all ones");
        step(1, 0, 1, 1, 8'hFE, "R3 load near top");
        step(1, 1, 1, 1, 8'h00, "R6 step to all ones");
        step(1, 1, 1, 1, 8'h00, "R7 chain wraps to zero");
        for (int i = 0; i < 300; i++)
            step(1, 1, 1, 1, 8'h00, "R6 R7 full cycle");
        step(0, 1, 1, 1, 8'h00, "R2 final clear");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: count=%0h tc=%0b expected run to end", count, tc_out);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule